// File: doc/BRIEF.md
# Single-Shot Pulse Width Capture Timer

This block holds a free-running counter and measures one pulse on a capture pin each time software arms it. After a correct arm sequence on a small synchronous register bus, the first rising edge on the capture pin stores the counter in a rise register. The next falling edge stores it in a fall register. Hardware then drops the arm bit, so both values stay frozen until software arms the block again. The pulse width is the fall value minus the rise value, modulo 2^CNT_W.

A general capture register also latches the counter on whichever capture-pin edges a two-bit mode selects. A select register picks one of two external pins. That pin can act as the counter's clock, so the counter steps on its rising edges instead of on the internal tick enable. It can also act as a reset, so its rising edge clears the counter. All three pins pass through a synchronizer chain before any edge is detected. Read data appears one cycle after the read strobe.

Top module: `pwcap_timer`

## Requirements
- R1: While armed and still waiting for a rise, a rising edge on the capture pin copies the counter into the rise register (address 2). The arm bit stays 1 afterwards.
- R2: After the rise, the next falling edge copies the counter into the fall register (address 3). A falling edge that comes before any rise leaves the block armed and the fall register untouched.
- R3: When that fall is captured, the arm bit returns to 0. Later pulses then change neither the rise register nor the fall register.
- R4: The arm bit is bit 0 of address 0. A write of 1 to it arms the block only if the most recent access before it was a read of address 0 that returned 0. Any write clears that read record, so a write of 1 with no such read, or after an intervening write, is ignored.
- R5: Bits 7:1 of address 0 read as 0. Bits 7:5 of address 1 read as 1. No write changes either set of bits.
- R6: Address 1 resets to 0xE0. Its bit 0 selects the external pin (0 = pin A, 1 = pin B). When its bit 2 is 1, a rising edge on the selected pin clears the counter to 0. The unselected pin has no effect.
- R7: When bit 1 of address 1 is 1, the counter steps once per rising edge of the selected pin, and the tick enable is ignored.
- R8: Otherwise the counter steps on each cycle with tick enable high and wraps from its maximum to 0. It reads at address 5. The measured width equals the fall value minus the rise value, modulo 2^CNT_W.
- R9: Bits 4:3 of address 1 set the general capture mode, read at address 4: 0 latches on rising edges, 1 on falling edges, 2 on both, 3 on none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | Internal count enable |
| capPin | input | 1 | Asynchronous capture input |
| extPinA | input | 1 | External clock/clear source A |
| extPinB | input | 1 | External clock/clear source B |
| addr | input | ADDR_W | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data, valid the cycle after rdEn |

## Verification
The bench uses the defaults: CNT_W = 8, ADDR_W = 3 and SYNC_STAGES = 2. With an 8-bit counter, a wrap occurs within a few hundred cycles, so the bench can run a pulse 300 cycles wide and expect a width of 44. With two synchronizer stages, the rise and fall paths have the same latency, so the expected width is exactly the number of cycles the pin is held high.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;
  localparam int DATA_W = 8;

  localparam int REG_ARM  = 0;
  localparam int REG_SEL  = 1;
  localparam int REG_RISE = 2;
  localparam int REG_FALL = 3;
  localparam int REG_GEN  = 4;
  localparam int REG_CNT  = 5;

  localparam logic [DATA_W-1:0] SEL_RESV_MASK = 8'hE0;

  typedef enum logic [1:0] {
    SEQ_IDLE      = 2'd0,
    SEQ_WAIT_RISE = 2'd1,
    SEQ_WAIT_FALL = 2'd2
  } seqState_t;

  typedef enum logic [1:0] {
    GC_RISE = 2'd0,
    GC_FALL = 2'd1,
    GC_BOTH = 2'd2,
    GC_OFF  = 2'd3
  } gcMode_t;

  typedef struct packed {
    logic latchRise;
    logic latchFall;
    logic latchGen;
    logic cntStep;
    logic cntClear;
  } dpStrobe_t;
endpackage

// File: rtl/pwcap_sync.sv
module pwcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pwcap_datapath.sv
module pwcap_datapath
  import pwcap_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capPin,
  input  logic [1:0]       extPins,
  input  dpStrobe_t        strobe,
  output logic             capRise,
  output logic             capFall,
  output logic [1:0]       extRise,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] riseCap,
  output logic [CNT_W-1:0] fallCap,
  output logic [CNT_W-1:0] genCap
);
  localparam int NUM_PINS = 3;

  logic [NUM_PINS-1:0] pinsRaw;
  logic [NUM_PINS-1:0] pinSync;
  logic [NUM_PINS-1:0] pinPrev;
  logic [NUM_PINS-1:0] pinRise;

  assign pinsRaw = {extPins, capPin};

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    pwcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (pinsRaw[gi]),
      .dout(pinSync[gi])
    );

    always_ff @(posedge clk) begin
      if (rst) pinPrev[gi] <= 1'b0;
      else     pinPrev[gi] <= pinSync[gi];
    end

    assign pinRise[gi] = pinSync[gi] & ~pinPrev[gi];
  end

  assign capRise = pinRise[0];
  assign capFall = ~pinSync[0] & pinPrev[0];
  assign extRise = pinRise[2:1];

  always_ff @(posedge clk) begin
    if (rst)                  cntVal <= '0;
    else if (strobe.cntClear) cntVal <= '0;
    else if (strobe.cntStep)  cntVal <= cntVal + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      riseCap <= '0;
      fallCap <= '0;
      genCap  <= '0;
    end else begin
      if (strobe.latchRise) riseCap <= cntVal;
      if (strobe.latchFall) fallCap <= cntVal;
      if (strobe.latchGen)  genCap  <= cntVal;
    end
  end
endmodule

// File: rtl/pwcap_ctrl.sv
module pwcap_ctrl
  import pwcap_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              capRise,
  input  logic              capFall,
  input  logic [1:0]        extRise,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  riseCap,
  input  logic [CNT_W-1:0]  fallCap,
  input  logic [CNT_W-1:0]  genCap,
  output logic [DATA_W-1:0] rdData,
  output dpStrobe_t         strobe,
  output logic              armed,
  output logic              readSeen
);
  seqState_t         seqQ, seqNext;
  logic [DATA_W-1:0] selQ;
  logic              hitArm, hitSel;
  logic              armReadZero, armRequest;
  logic              pinSel, extClk, extClr, selRise;
  gcMode_t           gcMode;
  logic [DATA_W-1:0] rdNext;

  assign hitArm = (addr == ADDR_W'(REG_ARM));
  assign hitSel = (addr == ADDR_W'(REG_SEL));
  assign armed  = (seqQ != SEQ_IDLE);

  assign armReadZero = rdEn && hitArm && !armed;
  assign armRequest  = wrEn && hitArm && wrData[0] && readSeen;

  always_ff @(posedge clk) begin
    if (rst)              readSeen <= 1'b0;
    else if (wrEn)        readSeen <= 1'b0;
    else if (armReadZero) readSeen <= 1'b1;
  end

  always_comb begin
    seqNext = seqQ;
    case (seqQ)
      SEQ_IDLE:      if (armRequest) seqNext = SEQ_WAIT_RISE;
      SEQ_WAIT_RISE: if (capRise)    seqNext = SEQ_WAIT_FALL;
      SEQ_WAIT_FALL: if (capFall)    seqNext = SEQ_IDLE;
      default:                       seqNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) seqQ <= SEQ_IDLE;
    else     seqQ <= seqNext;
  end

  always_ff @(posedge clk) begin
    if (rst)                 selQ <= SEL_RESV_MASK;
    else if (wrEn && hitSel) selQ <= wrData | SEL_RESV_MASK;
  end

  assign pinSel  = selQ[0];
  assign extClk  = selQ[1];
  assign extClr  = selQ[2];
  assign gcMode  = gcMode_t'(selQ[4:3]);
  assign selRise = extRise[pinSel];

  always_comb begin
    strobe.latchRise = (seqQ == SEQ_WAIT_RISE) && capRise;
    strobe.latchFall = (seqQ == SEQ_WAIT_FALL) && capFall;
    case (gcMode)
      GC_RISE: strobe.latchGen = capRise;
      GC_FALL: strobe.latchGen = capFall;
      GC_BOTH: strobe.latchGen = capRise | capFall;
      default: strobe.latchGen = 1'b0;
    endcase
    strobe.cntClear = extClr && selRise;
    strobe.cntStep  = extClk ? selRise : tickEn;
  end

  always_comb begin
    rdNext = '0;
    case (addr)
      ADDR_W'(REG_ARM):  rdNext[0] = armed;
      ADDR_W'(REG_SEL):  rdNext = selQ;
      ADDR_W'(REG_RISE): rdNext[CNT_W-1:0] = riseCap;
      ADDR_W'(REG_FALL): rdNext[CNT_W-1:0] = fallCap;
      ADDR_W'(REG_GEN):  rdNext[CNT_W-1:0] = genCap;
      ADDR_W'(REG_CNT):  rdNext[CNT_W-1:0] = cntVal;
      default:           rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end
endmodule

// File: rtl/pwcap_timer.sv
module pwcap_timer
  import pwcap_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              capPin,
  input  logic              extPinA,
  input  logic              extPinB,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  output logic [7:0]        rdData
);
  dpStrobe_t        strobe;
  logic             capRise, capFall;
  logic [1:0]       extRise;
  logic [CNT_W-1:0] cntVal, riseCap, fallCap, genCap;
  logic             armed, readSeen;

  pwcap_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .capPin (capPin),
    .extPins({extPinB, extPinA}),
    .strobe (strobe),
    .capRise(capRise),
    .capFall(capFall),
    .extRise(extRise),
    .cntVal (cntVal),
    .riseCap(riseCap),
    .fallCap(fallCap),
    .genCap (genCap)
  );

  pwcap_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .tickEn  (tickEn),
    .addr    (addr),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .rdEn    (rdEn),
    .capRise (capRise),
    .capFall (capFall),
    .extRise (extRise),
    .cntVal  (cntVal),
    .riseCap (riseCap),
    .fallCap (fallCap),
    .genCap  (genCap),
    .rdData  (rdData),
    .strobe  (strobe),
    .armed   (armed),
    .readSeen(readSeen)
  );
endmodule

// File: rtl/pwcap_timer_chk.sv
module pwcap_timer_chk
  import pwcap_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [7:0]        wrData,
  input logic              rdEn,
  input logic [7:0]        rdData,
  input logic              armed,
  input logic              readSeen,
  input dpStrobe_t         strobe,
  input logic [CNT_W-1:0]  riseCap,
  input logic [CNT_W-1:0]  fallCap,
  input logic [CNT_W-1:0]  cntVal
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_rise_while_armed_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(riseCap) |-> ($past(armed) && armed));

  p_fall_ends_seq_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(fallCap) |-> $fell(armed));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !armed |=> ($stable(riseCap) && $stable(fallCap)));

  p_arm_needs_read_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(wrEn && addr == ADDR_W'(REG_ARM) && wrData[0] && readSeen));

  p_write_drops_read_r4: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> !readSeen);

  p_arm_resv_zero_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rdEn && addr == ADDR_W'(REG_ARM)) |-> (rdData[7:1] == 7'd0));

  p_sel_resv_one_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rdEn && addr == ADDR_W'(REG_SEL)) |-> (rdData[7:5] == 3'b111));

  p_ext_clear_r6: assert property (@(posedge clk) disable iff (rst)
    strobe.cntClear |=> (cntVal == '0));

  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (cntVal == CNT_MAX && strobe.cntStep && !strobe.cntClear) |=> (cntVal == '0));
endmodule

bind pwcap_timer pwcap_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .rdEn    (rdEn),
  .rdData  (rdData),
  .armed   (armed),
  .readSeen(readSeen),
  .strobe  (strobe),
  .riseCap (riseCap),
  .fallCap (fallCap),
  .cntVal  (cntVal)
);

// File: tb/tb_pwcap_timer.sv
`timescale 1ns/1ps
module tb_pwcap_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickEn = 1'b0;
  logic       capPin = 1'b0;
  logic       extPinA = 1'b0;
  logic       extPinB = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic       rdScored = 1'b0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];
  logic     issued = 1'b0;

  always #2 clk = ~clk;

  pwcap_timer dut (
    .clk    (clk),
    .rst    (rst),
    .tickEn (tickEn),
    .capPin (capPin),
    .extPinA(extPinA),
    .extPinB(extPinB),
    .addr   (addr),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdEn   (rdEn),
    .rdData (rdData)
  );

  function automatic void check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endfunction

  // Monitor: pops the expected item matching each scored read.
  always @(posedge clk) issued <= rdEn && rdScored;

  always @(negedge clk) begin
    if (issued) begin
      if (expQ.size() == 0) begin
        check(1'b0, "scoreboard underflow", 0, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(rdData === it.val, it.tag, rdData, it.val);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdExpect(logic [2:0] a, logic [7:0] e, string tag);
    expItem_t it;
    @(negedge clk);
    it.val = e; it.tag = tag;
    expQ.push_back(it);
    addr = a; rdEn = 1'b1; rdScored = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; rdScored = 1'b0;
  endtask

  task automatic rdValue(logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic armSeq();
    rdExpect(3'd0, 8'h00, "R4 arm reads 0 before arming");
    wr(3'd0, 8'h01);
  endtask

  task automatic runTicks(int n);
    @(negedge clk);
    tickEn = 1'b1;
    tick(n);
    tickEn = 1'b0;
  endtask

  task automatic pulsePin(int which, int hi, int lo);
    @(negedge clk);
    if (which == 0) extPinA = 1'b1; else extPinB = 1'b1;
    tick(hi);
    if (which == 0) extPinA = 1'b0; else extPinB = 1'b0;
    tick(lo);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 0);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] r, f, v, v2, w, a, b, r0, f0;
    tick(4);
    rst = 1'b0;

    // Reset state
    rdExpect(3'd0, 8'h00, "R5 arm register reset");
    rdExpect(3'd1, 8'hE0, "R6 select register reset");
    rdExpect(3'd2, 8'h00, "R1 rise register reset");
    rdExpect(3'd3, 8'h00, "R2 fall register reset");
    rdExpect(3'd4, 8'h00, "R9 general capture reset");
    rdExpect(3'd5, 8'h00, "R8 counter reset");

    // R4: arming rules
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h01);
    rdExpect(3'd0, 8'h00, "R4 write 1 without prior read ignored");
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h01);
    rdExpect(3'd0, 8'h00, "R4 intervening write cancels read");
    wr(3'd0, 8'hFE);
    rdExpect(3'd0, 8'h00, "R5 reserved arm bits stay 0");

    // Fall before rise ignored (R2)
    @(negedge clk); capPin = 1'b1;
    tick(5);
    wr(3'd0, 8'h01);
    rdExpect(3'd0, 8'h01, "R4 arm after read of 0");
    @(negedge clk); capPin = 1'b0;
    tick(5);
    rdExpect(3'd0, 8'h01, "R2 early fall leaves block armed");
    rdExpect(3'd3, 8'h00, "R2 early fall leaves fall register");

    // Width measurement with counter running (R8, R3)
    @(negedge clk); tickEn = 1'b1; capPin = 1'b1;
    tick(20);
    capPin = 1'b0;
    tick(6);
    rdExpect(3'd0, 8'h00, "R3 arm clears after rise then fall");
    rdValue(3'd2, r0);
    rdValue(3'd3, f0);
    w = f0 - r0;
    check(w == 8'd20, "R8 width of 20-cycle pulse", w, 20);
    @(negedge clk); capPin = 1'b1;
    tick(7);
    capPin = 1'b0;
    tick(6);
    rdValue(3'd2, r);
    rdValue(3'd3, f);
    check(r == r0, "R3 rise register holds after disarm", r, r0);
    check(f == f0, "R3 fall register holds after disarm", f, f0);

    // Exact capture values with frozen counter (R1, R2)
    @(negedge clk); tickEn = 1'b0;
    rdValue(3'd5, v);
    armSeq();
    @(negedge clk); capPin = 1'b1;
    tick(5);
    rdExpect(3'd2, v, "R1 rise captures counter");
    rdExpect(3'd0, 8'h01, "R1 still armed after rise");
    runTicks(3);
    v2 = v + 8'd3;
    @(negedge clk); capPin = 1'b0;
    tick(5);
    rdExpect(3'd3, v2, "R2 fall captures counter");
    rdExpect(3'd0, 8'h00, "R3 disarmed after capture");

    // Wrapping pulse width (R8)
    armSeq();
    @(negedge clk); tickEn = 1'b1; capPin = 1'b1;
    tick(300);
    capPin = 1'b0;
    tick(6);
    tickEn = 1'b0;
    rdValue(3'd2, r);
    rdValue(3'd3, f);
    w = f - r;
    check(w == 8'd44, "R8 width wraps modulo 256", w, 44);

    // Counter wrap (R8)
    rdValue(3'd5, a);
    runTicks(260);
    rdValue(3'd5, b);
    check(b == 8'(a + 8'd4), "R8 counter wraps after 260 ticks", b, 8'(a + 8'd4));

    // External clear (R6)
    wr(3'd1, 8'h05);
    rdExpect(3'd1, 8'hE5, "R6 select readback");
    pulsePin(0, 4, 4);
    rdExpect(3'd5, b, "R6 unselected pin does not clear");
    pulsePin(1, 4, 4);
    rdExpect(3'd5, 8'h00, "R6 selected pin clears counter");

    // External clock (R7)
    wr(3'd1, 8'h02);
    @(negedge clk); tickEn = 1'b1;
    for (int i = 0; i < 5; i++) pulsePin(0, 3, 3);
    for (int i = 0; i < 2; i++) pulsePin(1, 3, 3);
    tickEn = 1'b0;
    rdExpect(3'd5, 8'd5, "R7 counter steps on selected pin only");

    // General capture modes (R9); counter is 5
    wr(3'd1, 8'h00);
    @(negedge clk); capPin = 1'b1;
    tick(4);
    rdExpect(3'd4, 8'd5, "R9 rise mode latches on rise");
    runTicks(10);
    wr(3'd1, 8'h08);
    @(negedge clk); capPin = 1'b0;
    tick(4);
    rdExpect(3'd4, 8'd15, "R9 fall mode latches on fall");
    runTicks(10);
    @(negedge clk); capPin = 1'b1;
    tick(4);
    rdExpect(3'd4, 8'd15, "R9 fall mode ignores rise");
    wr(3'd1, 8'h18);
    @(negedge clk); capPin = 1'b0;
    tick(4);
    rdExpect(3'd4, 8'd15, "R9 off mode ignores fall");
    wr(3'd1, 8'h10);
    @(negedge clk); capPin = 1'b1;
    tick(4);
    rdExpect(3'd4, 8'd25, "R9 both mode latches on rise");

    // Reserved select bits (R5)
    wr(3'd1, 8'hFF);
    rdExpect(3'd1, 8'hFF, "R5 select writable bits set");
    wr(3'd1, 8'h00);
    rdExpect(3'd1, 8'hE0, "R5 select reserved bits stay 1");

    tick(4);
    summary();
    $finish;
  end
endmodule